// File: doc/BRIEF.md
# Floating-Point Trap Enable and Arbitration Unit

This block keeps a 32-bit floating-point control word and decides when a floating-point exception turns into a trap. The upper half of the word is reserved. The lower half holds two bytes. One is a byte of per-class trap enables. The other is a byte of user mode bits, which the block only stores. Software reaches the word through a single-cycle register port: a write strobe with write data, and read data that is always valid.

The execution datapath presents an 8-bit exception-status byte together with a one-cycle completion strobe each time an instruction finishes. On the cycle after the strobe, the block compares the sampled status byte with the enables. If any enabled class is flagged, it pulses a trap request for one cycle and gives a 3-bit class index. The index names only the highest-priority class. Lower-priority classes that were flagged in the same completion are dropped and are not held for later. An exception flagged before an enable was turned on never traps, because the status byte is looked at only when a completion strobe arrives.

A reset or a null-state restore clears the whole word. The all-zero word disables every trap.

Top module: `fp_trap_ctl`

## Requirements
- R1: After reset, read data is 0 and the trap request is low.
- R2: Bits 31..16 of read data are always 0, whatever was written to them.
- R3: A write stores write-data bits 15..8 as the enable byte and bits 7..0 as the mode byte. Read data shows both from the cycle after the write.
- R4: On the cycle after a completion strobe, the trap request is high exactly when (status & enable) is nonzero. Status bit k pairs with enable bit k+8.
- R5: The trap request is a single-cycle pulse. It is low in every cycle that does not directly follow a completion strobe.
- R6: The trap index is the highest set bit of (status & enable), encoded as 7 minus that bit position. Status bit 7 gives index 0 and status bit 0 gives index 7. Lower classes flagged in the same completion are never reported.
- R7: Turning on an enable produces no trap for a status byte that was presented before the write. Only a later completion strobe can trap.
- R8: When a write and a completion strobe arrive in the same cycle, the trap decision uses the enable byte from before the write.
- R9: A null-state restore pulse clears the whole word to zero on the next cycle. If a write arrives in the same cycle, the restore wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| null_restore | input | 1 | Clears the control word |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data, reserved bits forced to zero |
| insn_done | input | 1 | Instruction completion strobe |
| exc_status | input | 8 | Exception-status byte, sampled on insn_done |
| trap_req | output | 1 | One-cycle trap request |
| trap_idx | output | 3 | Index of the reported class, 0 = highest priority |

## Verification
The bench builds the block with its default class count of eight, which is the only width the block defines. At that width the bench can drive every one-hot status pattern across the full priority range from index 0 to index 7. It also runs dual and triple exceptions with partial enable masks. These show that the lowest-numbered enabled class is reported and that the masked or lower classes are dropped.

// File: rtl/fp_trap_ctl.sv
module fp_trap_ctl #(
  parameter int NCLS = 8,
  localparam int IW = $clog2(NCLS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            null_restore,
  input  logic            wr_en,
  input  logic [31:0]     wr_data,
  output logic [31:0]     rd_data,
  input  logic            insn_done,
  input  logic [NCLS-1:0] exc_status,
  output logic            trap_req,
  output logic [IW-1:0]   trap_idx
);
  logic [NCLS-1:0] enab;
  logic [7:0]      mode;
  logic [NCLS-1:0] hit;
  logic [IW-1:0]   pick;

  assign hit = insn_done ? (exc_status & enab) : '0;

  always_comb begin
    pick = '0;
    for (int i = 0; i < NCLS; i++)
      if (hit[i]) pick = IW'(NCLS - 1 - i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || null_restore) begin
      enab <= '0;
      mode <= '0;
    end else if (wr_en) begin
      enab <= wr_data[8 +: NCLS];
      mode <= wr_data[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_req <= 1'b0;
      trap_idx <= '0;
    end else begin
      trap_req <= |hit;
      trap_idx <= pick;
    end
  end

  assign rd_data = {{(24 - NCLS){1'b0}}, enab, mode};
endmodule

// File: rtl/fp_trap_ctl_chk.sv
module fp_trap_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        null_restore,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        insn_done,
  input logic [7:0]  exc_status,
  input logic        trap_req,
  input logic [2:0]  trap_idx
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rd_data[31:16] == 16'h0); // R2
  AST_WRITE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !null_restore |=> rd_data[15:0] == $past(wr_data[15:0])); // R3
  AST_TRAP_DECIDE: assert property (@(posedge clk) disable iff (!rst_n)
    insn_done && !$past(!rst_n) |=> trap_req == |($past(exc_status) & $past(rd_data[15:8]))); // R4
  AST_NO_STRAY_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_done |=> !trap_req); // R5
  AST_IDX_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    insn_done && !$past(!rst_n) |=> !trap_req || (($past(exc_status) & $past(rd_data[15:8])) >> (7 - trap_idx)) == 8'h1); // R6
  AST_RESTORE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    null_restore |=> rd_data == 32'h0); // R9
endmodule

bind fp_trap_ctl fp_trap_ctl_chk u_chk (.*);

// File: tb/fp_trap_ctl_test.sv
module fp_trap_ctl_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        null_restore = 0;
  logic        wr_en = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic        insn_done = 0;
  logic [7:0]  exc_status = 0;
  logic        trap_req;
  logic [2:0]  trap_idx;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  fp_trap_ctl uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk); #2; endtask

  task automatic wr(logic [31:0] d);
    wr_en = 1; wr_data = d; tick(); wr_en = 0;
  endtask

  function automatic logic [2:0] ref_idx(logic [7:0] h);
    for (int b = 7; b >= 0; b--) if (h[b]) return 3'(7 - b);
    return 0;
  endfunction

  task automatic complete(logic [7:0] st, logic [7:0] en, string req);
    exc_status = st; insn_done = 1; tick(); insn_done = 0; exc_status = 0;
    chk(req, trap_req, |(st & en));
    if (|(st & en)) chk(req, trap_idx, ref_idx(st & en));
    tick();
    chk("R5", trap_req, 0);
  endtask

  task automatic t_reset;
    chk("R1", rd_data, 0);
    chk("R1", trap_req, 0);
  endtask

  task automatic t_regs;
    wr(32'hDEAD_A55A);
    chk("R2", rd_data[31:16], 0);
    chk("R3", rd_data, 32'h0000_A55A);
    wr(32'hFFFF_0000);
    chk("R2", rd_data, 0);
  endtask

  task automatic t_decide;
    wr(32'h0000_FF00);
    for (int b = 0; b < 8; b++) complete(8'(1 << b), 8'hFF, "R6");
    wr(32'h0000_0F00);
    complete(8'hF0, 8'h0F, "R4");
    complete(8'h30, 8'h0F, "R4");
    complete(8'h31, 8'h0F, "R4");
    complete(8'h07, 8'h0F, "R6");
    wr(32'h0000_2900);
    complete(8'hE1, 8'h29, "R6");
    complete(8'h09, 8'h29, "R6");
  endtask

  task automatic t_late_enable;
    wr(32'h0);
    exc_status = 8'h80;
    tick(); tick();
    wr(32'h0000_8000);
    tick();
    chk("R7", trap_req, 0);
    tick();
    chk("R7", trap_req, 0);
    exc_status = 0;
    complete(8'h80, 8'h80, "R7");
  endtask

  task automatic t_same_cycle;
    wr(32'h0);
    wr_en = 1; wr_data = 32'h0000_0400; exc_status = 8'h04; insn_done = 1;
    tick();
    wr_en = 0; insn_done = 0; exc_status = 0;
    chk("R8", trap_req, 0);
    chk("R8", rd_data, 32'h400);
    wr_en = 1; wr_data = 32'h0; exc_status = 8'h04; insn_done = 1;
    tick();
    wr_en = 0; insn_done = 0; exc_status = 0;
    chk("R8", trap_req, 1);
    chk("R8", trap_idx, 5);
  endtask

  task automatic t_restore;
    wr(32'h0000_FF77);
    null_restore = 1; tick(); null_restore = 0;
    chk("R9", rd_data, 0);
    complete(8'hFF, 8'h00, "R9");
    wr(32'h0000_1111);
    null_restore = 1; wr_en = 1; wr_data = 32'h0000_ABCD; tick();
    null_restore = 0; wr_en = 0;
    chk("R9", rd_data, 0);
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1;
    tick();
    t_reset();
    t_regs();
    t_decide();
    t_late_enable();
    t_same_cycle();
    t_restore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule